// File: doc/BRIEF.md
# Pattern-Gated Receive Bit FIFO

This block sits behind a bit recovery circuit and buffers the recovered data bits. Each bit arrives on a valid/ready input stream. While the block is armed it shifts every accepted bit through a search register and compares the last sixteen bits with a programmable synchronisation word. Until that comparison succeeds nothing is stored. After the match, every accepted bit goes into a small bit FIFO, sixteen entries deep by default. This continues until software drops the enable bit and raises it again, which flushes the buffer and starts a fresh search.

A fill-level interrupt, driven in both polarities, fires once the number of buffered bits reaches a programmed threshold. A threshold of one (or zero) turns it into a not-empty flag. The host drains the buffer serially. While the active-low select input is held low, the oldest bit appears on the serial data output, and each rising edge of the serial clock discards that bit and presents the next one. The serial clock is sampled in the block's clock domain, so it must run well below the system clock.

The input stream never applies back-pressure because of buffer occupancy. Ready follows the enable bit only. A bit that arrives while the buffer is full is discarded, and a sticky overflow flag records the loss.

Top module: `rxbit_sync_fifo`

## Requirements
- R1: After reset, irq is 0, irq_n is 1, sdo is 0, overflow is 0, and the buffer and the search are empty.
- R2: in_ready equals fifo_en. A bit offered while fifo_en is 0 is not accepted and changes no state.
- R3: Accepted bits shift into the search register with the first-received bit ending up in bit 15. A match is declared when that register, including the current bit, equals sync_word, and only once at least 16 bits have been accepted since arming. The matching bit itself is not stored, and no bit is stored before a match.
- R4: After a match, every accepted bit is stored in arrival order, with no further pattern checking, until re-arming.
- R5: While fifo_en is 0 the buffer is flushed, overflow is cleared and the search restarts. Raising fifo_en again re-arms the search.
- R6: irq is 1 exactly when the buffered bit count is at least max(irq_level,1). irq_n is always its complement. With irq_level of 0 or 1, irq acts as a not-empty flag.
- R7: sdo shows the oldest buffered bit while sel_n is 0. It is 0 while sel_n is 1 or the buffer is empty.
- R8: A rising edge on sck while sel_n is 0 removes the oldest bit. sck edges while sel_n is 1 remove nothing.
- R9: A removal request on an empty buffer is ignored. The count does not wrap, and the next stored bit becomes the oldest.
- R10: A bit accepted while the buffer holds DEPTH bits and no removal occurs in the same cycle is dropped. Overflow is then set and stays set until re-arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Enable bit; low flushes and re-arms |
| sync_word | input | 16 | Synchronisation pattern |
| irq_level | input | 5 | Fill threshold for the interrupt |
| in_valid | input | 1 | Recovered bit strobe |
| in_bit | input | 1 | Recovered bit value |
| in_ready | output | 1 | Bit accepted when high with in_valid |
| sel_n | input | 1 | Active-low buffer select for serial read |
| sck | input | 1 | Serial read clock, sampled in the clk domain |
| sdo | output | 1 | Serial data out, oldest bit |
| irq | output | 1 | Fill-level interrupt, active high |
| irq_n | output | 1 | Fill-level interrupt, active low |
| overflow | output | 1 | Sticky lost-bit flag |

## Verification
The hardest state to reach from the ports is a match that must not happen: a search register that holds the sync word in some shifted form, or an all-zero register that equals an all-zero sync word before sixteen bits have been seen. The stimulus re-arms the block with a zero sync word and feeds fifteen zeros, then a sixteenth. It also feeds an alternating preamble ahead of a non-periodic pattern. In both cases the interrupt must stay quiet until the exact bit that completes the word. Overflow is reached by locking, streaming seventeen bits without a read, and then draining to confirm the first sixteen bits survived.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // width of a counter able to hold the value n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rxf_sync_hunt.sv
module rxf_sync_hunt #(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             take,
  input  logic             bit_val,
  input  logic [PAT_W-1:0] pattern,
  output logic             locked
);
  localparam int SW = rxf_pkg::cnt_width(PAT_W);
  localparam logic [SW-1:0] FULL_SEEN = SW'(PAT_W);
  localparam logic [SW-1:0] LAST_SEEN = SW'(PAT_W - 1);

  logic [PAT_W-1:0] hist;
  logic [SW-1:0]    seen;
  logic [PAT_W-1:0] window;

  assign window = {hist[PAT_W-2:0], bit_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      seen   <= '0;
      locked <= 1'b0;
    end else if (!arm) begin
      hist   <= '0;
      seen   <= '0;
      locked <= 1'b0;
    end else if (take && !locked) begin
      hist <= window;
      if (seen != FULL_SEEN) seen <= seen + 1'b1;
      if (window == pattern && seen >= LAST_SEEN) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/rxf_bit_store.sv
module rxf_bit_store #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_req,
  input  logic          push_bit,
  input  logic          pop_req,
  output logic          head_bit,
  output logic [CW-1:0] fill,
  output logic          overflow
);
  localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam bit POW2 = ((1 << AW) == DEPTH);

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic             pop_ok, push_ok;

  assign pop_ok  = pop_req && (fill != '0);
  assign push_ok = push_req && ((fill != FULL) || pop_ok);
  assign head_bit = mem[rd_ptr];

  generate
    if (POW2) begin : g_wrap_nat
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem      <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) begin
        mem[wr_ptr] <= push_bit;
        wr_ptr      <= wr_nxt;
      end
      if (pop_ok) rd_ptr <= rd_nxt;
      if (push_ok && !pop_ok) fill <= fill + 1'b1;
      else if (pop_ok && !push_ok) fill <= fill - 1'b1;
      if (push_req && !push_ok) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rxf_serial_rd.sv
module rxf_serial_rd (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sck,
  input  logic head_bit,
  input  logic nonempty,
  output logic sdo,
  output logic pop
);
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign pop = !sel_n && sck && !sck_q;
  assign sdo = !sel_n && nonempty && head_bit;
endmodule

// File: rtl/rxbit_sync_fifo.sv
module rxbit_sync_fifo #(
  parameter int DEPTH = 16,
  parameter int PAT_W = 16,
  parameter int LW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [PAT_W-1:0] sync_word,
  input  logic [LW-1:0]    irq_level,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  input  logic             sel_n,
  input  logic             sck,
  output logic             sdo,
  output logic             irq,
  output logic             irq_n,
  output logic             overflow
);
  localparam int CW = rxf_pkg::cnt_width(DEPTH);
  localparam int TW = (CW > LW) ? CW : LW;

  logic          take, locked, head_bit, pop;
  logic [CW-1:0] fill;
  logic [TW-1:0] thr;

  assign in_ready = fifo_en;
  assign take     = in_valid && fifo_en;

  rxf_sync_hunt #(.PAT_W(PAT_W)) u_hunt (
    .clk(clk), .rst_n(rst_n), .arm(fifo_en), .take(take),
    .bit_val(in_bit), .pattern(sync_word), .locked(locked)
  );

  rxf_bit_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(!fifo_en),
    .push_req(take && locked), .push_bit(in_bit), .pop_req(pop),
    .head_bit(head_bit), .fill(fill), .overflow(overflow)
  );

  rxf_serial_rd u_rd (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck),
    .head_bit(head_bit), .nonempty(fill != '0), .sdo(sdo), .pop(pop)
  );

  assign thr   = (irq_level == '0) ? TW'(1) : TW'(irq_level);
  assign irq   = TW'(fill) >= thr;
  assign irq_n = !irq;
endmodule

// File: rtl/rxbit_sync_fifo_chk.sv
module rxbit_sync_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          sel_n,
  input logic          sdo,
  input logic          irq,
  input logic          overflow,
  input logic [CW-1:0] fill
);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && fifo_en) |=> overflow);
  // R5
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (!overflow && !irq && fill == '0));
  // R7
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || fill == '0) |-> !sdo);
  // R9
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  // R4
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == $past(fill)) || (fill == $past(fill) + 1'b1) ||
    (fill + 1'b1 == $past(fill)) || (fill == '0));
endmodule

bind rxbit_sync_fifo rxbit_sync_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .sel_n(sel_n), .sdo(sdo),
  .irq(irq), .overflow(overflow), .fill(fill)
);

// File: tb/rxbit_sync_fifo_test.sv
module rxbit_sync_fifo_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic sel_n = 1'b1, sck = 1'b0;
  logic [15:0] sync_word = 16'h2DD4;
  logic [4:0]  irq_level = 5'd1;
  logic in_ready, sdo, irq, irq_n, overflow;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rxbit_sync_fifo uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .sync_word(sync_word),
    .irq_level(irq_level), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .sel_n(sel_n), .sck(sck), .sdo(sdo),
    .irq(irq), .irq_n(irq_n), .overflow(overflow)
  );

  // {sync, payload (sent from bit 15 down), count, irq level}
  localparam logic [41:0] VEC [5] = '{
    {16'h2DD4, 16'hA5C3, 5'd8,  5'd8},
    {16'hF0F0, 16'h1234, 5'd4,  5'd1},
    {16'h8001, 16'hFFFF, 5'd16, 5'd16},
    {16'h0F0F, 16'h5555, 5'd3,  5'd5},
    {16'hCAFE, 16'h0000, 5'd0,  5'd0}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); in_valid = 1'b1; in_bit = b;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w, input int n);
    for (int i = 15; i > 15 - n; i--) send_bit(w[i]);
  endtask

  task automatic rearm;
    @(negedge clk); fifo_en = 1'b0;
    @(negedge clk); fifo_en = 1'b1;
  endtask

  task automatic read_pulse;
    @(negedge clk); sck = 1'b1;
    @(negedge clk); sck = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 1'b0);
    chk("R1 irq_n", irq_n, 1'b1);
    chk("R1 sdo", sdo, 1'b0);
    chk("R1 overflow", overflow, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 ready follows enable, disabled bits ignored
    chk("R2 ready low", in_ready, 1'b0);
    send_word(16'h2DD4, 16); send_bit(1'b1);
    fifo_en = 1'b1; @(negedge clk);
    chk("R2 ready high", in_ready, 1'b1);
    chk("R2 nothing stored", irq, 1'b0);

    // table walk: R3 R4 R6 R7 R8
    foreach (VEC[k]) begin
      logic [15:0] sw, pl; logic [4:0] n, lv;
      {sw, pl, n, lv} = VEC[k];
      sync_word = sw; irq_level = lv;
      rearm();
      send_word(sw, 16);
      chk("R3 match bit not stored", irq, 1'b0);
      send_word(pl, int'(n));
      chk("R6 irq level", irq, (n >= ((lv == 0) ? 5'd1 : lv)));
      chk("R6 irq_n", irq_n, !(n >= ((lv == 0) ? 5'd1 : lv)));
      sel_n = 1'b0;
      for (int i = 0; i < int'(n); i++) begin
        @(negedge clk);
        chk("R4 R7 bit order", sdo, pl[15 - i]);
        read_pulse();
      end
      @(negedge clk);
      chk("R7 empty sdo", sdo, 1'b0);
      chk("R8 drained", irq, 1'b0);
      sel_n = 1'b1;
    end

    // R3 preamble before pattern
    sync_word = 16'h2DD4; irq_level = 5'd1;
    rearm();
    send_word(16'hAAAA, 16);
    chk("R3 no store before match", irq, 1'b0);
    send_word(16'h2DD4, 16); send_bit(1'b1);
    chk("R3 lock after preamble", irq, 1'b1);

    // R8 read with select high removes nothing
    read_pulse();
    @(negedge clk);
    chk("R7 sdo idle when deselected", sdo, 1'b0);
    sel_n = 1'b0; @(negedge clk);
    chk("R8 bit kept", sdo, 1'b1);
    read_pulse();
    // R9 pop from empty
    read_pulse(); read_pulse();
    chk("R9 empty stays", irq, 1'b0);
    send_bit(1'b1);
    chk("R9 no wrap", irq, 1'b1);
    chk("R9 head is new bit", sdo, 1'b1);
    sel_n = 1'b1;

    // R3 all-zero pattern needs 16 bits
    sync_word = 16'h0000;
    rearm();
    send_word(16'h0000, 15); send_bit(1'b1);
    chk("R3 early zero window", irq, 1'b0);
    rearm();
    send_word(16'h0000, 16); send_bit(1'b1);
    chk("R3 zero pattern lock", irq, 1'b1);

    // R10 overflow
    sync_word = 16'h2DD4; irq_level = 5'd16;
    rearm();
    send_word(16'h2DD4, 16);
    send_word(16'hC33C, 16);
    chk("R10 full no ovf", overflow, 1'b0);
    chk("R6 full irq", irq, 1'b1);
    send_bit(1'b1);
    chk("R10 overflow set", overflow, 1'b1);
    sel_n = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R10 kept bits", sdo, 16'hC33C >> (15 - i) & 1'b1);
      read_pulse();
    end
    sel_n = 1'b1; @(negedge clk);
    chk("R10 sticky", overflow, 1'b1);
    // R5 re-arm clears and restarts search
    irq_level = 5'd1;
    rearm();
    chk("R5 overflow cleared", overflow, 1'b0);
    send_word(16'hFFFF, 16);
    chk("R5 search restarted", irq, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule